// File: doc/BRIEF.md
# Block Transfer Engine with Burst and Cycle-Steal Bus Ownership

This block moves a block of bytes between memory and a single peripheral without the processor taking part. Software first writes a start address and a word count, then writes a control word. The control word picks the transfer direction and the ownership mode and arms the channel. Once armed, the engine waits for the peripheral's request. It then raises a hold request to the processor and touches the memory bus only after the processor has returned a hold grant.

In burst mode the engine keeps the bus from the first word to the last and moves one word per clock. In cycle-steal mode it moves a single word per grant. It waits for a cycle in which the processor reports the bus idle, takes the bus for that one word and hands it back at once. After every word the address steps up by one and the count steps down by one. When the count runs out, the done flag rises. A zero count finishes immediately and never asks for the bus.

Top module: `dmac_top`

## Requirements
- R1: While reset is held and in the first cycle after it, hold_req, mem_en, mem_we, periph_ack and done are all 0.
- R2: mem_en and periph_ack are high only in cycles where hold_req and hold_ack are both high. A transfer starts only while periph_req is high.
- R3: The words of a block are moved at addresses start, start+1, … up to start+count-1, in that order, with exactly one periph_ack pulse per word. No address outside that range is touched.
- R4: In burst mode (control bit0 = 0), hold_req rises once per block and stays high until the last word. Once the grant arrives, words are moved on consecutive clocks. hold_req falls in the cycle after the last word.
- R5: Control bit1 selects the direction. With bit1 = 0 the data goes from memory to the peripheral: mem_we = 0 and periph_wdata carries mem_rdata. With bit1 = 1 the data goes from the peripheral to memory: mem_we = 1 and mem_wdata carries periph_rdata.
- R6: In cycle-steal mode (control bit0 = 1), each hold grant carries exactly one word and hold_req falls in the cycle after that word. No new hold request is made until hold_ack has dropped.
- R7: In cycle-steal mode a hold request is raised only in a cycle where both bus_idle and periph_req are high. In either mode, no hold request is made while periph_req stays low.
- R8: done rises in the cycle after the last word and clears in the cycle after arming. Arming with a count of 0 sets done in the next cycle without raising hold_req.
- R9: The register port uses cfg_sel 0 = start address, 1 = word count and 2 = control, where bit2 = go. Writes made while a block is armed or running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | CFG_W | Register write data |
| periph_req | input | 1 | Peripheral asks for a transfer |
| periph_ack | output | 1 | One pulse per word moved |
| periph_rdata | input | DATA_W | Data from the peripheral |
| periph_wdata | output | DATA_W | Data to the peripheral |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Processor has released the buses |
| bus_idle | input | 1 | Processor is not using the bus this cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle |
| mem_en | output | 1 | Memory access strobe of the engine |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | Block finished |

## Verification
A register write can land in the same cycle as an armed channel. It can also land while the channel waits for its grant, at the moment it is about to step the address. The bench provokes this by holding periph_req low after arming, writing a new start address and then releasing the request. It then judges the result by checking that the peripheral received bytes from the original address range and that the block finished with the original count. A second overlap is the end of one stolen cycle against the next request. The bench keeps bus_idle and periph_req high throughout, so the engine would re-request at once if it could. It judges the result by counting exactly one hold rise per word and no access without a live grant.

// File: rtl/dmac_pkg.sv
// Shared types for the block transfer engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dmac_pkg;

    // Sequencer states of the bus-ownership controller
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // nothing armed
        ST_ARMED = 2'd1,   // waiting for request (and idle bus in steal mode)
        ST_WAIT  = 2'd2,   // hold raised, waiting for grant
        ST_XFER  = 2'd3    // bus owned, one word per cycle
    } dmac_state_e;

    // Register select codes on the configuration port
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Bit positions inside the control word
    localparam int CTRL_STEAL = 0;
    localparam int CTRL_DIR   = 1;
    localparam int CTRL_GO    = 2;

endpackage

// File: rtl/dmac_regs.sv
// Configuration and working registers of the transfer engine.
// The start address and count written by software are the working counters
// themselves: each moved word steps them. Writes are accepted only while the
// sequencer reports not busy. Assumes CFG_W >= ADDR_W and CFG_W >= CNT_W.
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              busy,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              mode_steal,
    output logic              dir_p2m,
    output logic              go,
    output logic              cnt_zero,
    output logic              cnt_last
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic wr_ok;

    // Purpose: accept software writes only when the channel is idle
    always_comb begin
        wr_ok    = cfg_we && !busy;
        go       = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_GO];
        cnt_zero = (cnt == '0);
        cnt_last = (cnt == CNT_ONE);
    end

    // Purpose: hold address, count and mode; step counters per moved word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr       <= '0;
            cnt        <= '0;
            mode_steal <= 1'b0;
            dir_p2m    <= 1'b0;
        end else if (step) begin
            addr <= addr + 1'b1;
            cnt  <= cnt - 1'b1;
        end else if (wr_ok) begin
            case (cfg_sel)
                SEL_ADDR: addr <= cfg_wdata[ADDR_W-1:0];
                SEL_CNT:  cnt  <= cfg_wdata[CNT_W-1:0];
                SEL_CTRL: begin
                    mode_steal <= cfg_wdata[CTRL_STEAL];
                    dir_p2m    <= cfg_wdata[CTRL_DIR];
                end
                default: ;
            endcase
        end
    end

    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr == $past(addr) + 1'b1)); // R3

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> ($stable(addr) && $stable(cnt) && $stable(mode_steal))); // R9

endmodule

// File: rtl/dmac_seq.sv
// Bus-ownership sequencer. It waits for the peripheral request (and, in steal
// mode, for a bus-idle cycle), raises hold, waits for the grant and then fires
// one word per cycle. Burst mode keeps the bus to the end of the block; steal
// mode returns it after every word. Assumes hold_ack falls some cycles after
// hold_req falls; a new request is only made once hold_ack is low.
module dmac_seq
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic mode_steal,
    input  logic periph_req,
    input  logic bus_idle,
    input  logic hold_ack,
    output logic hold_req,
    output logic fire,
    output logic busy,
    output logic done
);

    dmac_state_e state_q, state_d;
    logic        start_ok;
    logic        done_d;

    // Purpose: decode outputs and the start condition from the current state
    always_comb begin
        hold_req = (state_q == ST_WAIT) || (state_q == ST_XFER);
        fire     = (state_q == ST_XFER) && hold_ack;
        busy     = (state_q != ST_IDLE);
        start_ok = periph_req && !hold_ack && (!mode_steal || bus_idle);
    end

    // Purpose: next-state and done-flag logic
    always_comb begin
        state_d = state_q;
        done_d  = done;
        case (state_q)
            ST_IDLE: begin
                if (go) begin
                    done_d  = cnt_zero;
                    state_d = cnt_zero ? ST_IDLE : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (start_ok) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (hold_ack) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (fire) begin
                    if (cnt_last) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else if (mode_steal) begin
                        state_d = ST_ARMED;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= done_d;
        end
    end

    AST_ACCESS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (hold_ack && hold_req)); // R2

    AST_ZERO_COUNT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt_zero) |=> (done && !hold_req)); // R8

    AST_HOLD_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> $past(periph_req)); // R7

endmodule

// File: rtl/dmac_top.sv
// Top of the block transfer engine: register block, sequencer and the
// combinational data steering between memory and peripheral. Memory read data
// is expected in the same cycle as mem_en; the peripheral takes or gives one
// word on every periph_ack pulse.
module dmac_top
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int CFG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              periph_req,
    output logic              periph_ack,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic [DATA_W-1:0] periph_wdata,
    output logic              hold_req,
    input  logic              hold_ack,
    input  logic              bus_idle,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic              done
);

    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    logic              mode_steal, dir_p2m, go, cnt_zero, cnt_last;
    logic              busy, fire;

    dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .step       (fire),
        .addr       (addr),
        .cnt        (cnt),
        .mode_steal (mode_steal),
        .dir_p2m    (dir_p2m),
        .go         (go),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last)
    );

    dmac_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .mode_steal (mode_steal),
        .periph_req (periph_req),
        .bus_idle   (bus_idle),
        .hold_ack   (hold_ack),
        .hold_req   (hold_req),
        .fire       (fire),
        .busy       (busy),
        .done       (done)
    );

    // Purpose: steer addresses, strobes and data for the word being moved
    always_comb begin
        mem_addr     = addr;
        mem_en       = fire;
        mem_we       = fire && dir_p2m;
        periph_ack   = fire;
        mem_wdata    = periph_rdata;
        periph_wdata = mem_rdata;
    end

    AST_BURST_HOLD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_req) && !mode_steal) |-> done); // R4

    AST_STEAL_ONE_PER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_ack && mode_steal) |=> (!hold_req && !periph_ack)); // R6

    AST_BUS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> hold_ack); // R2

endmodule

// File: tb/dmac_top_tb_top.sv
module dmac_top_tb_top;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CFG_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [1:0]        cfg_sel;
    logic [CFG_W-1:0]  cfg_wdata;
    logic              periph_req;
    logic              periph_ack;
    logic [DATA_W-1:0] periph_rdata;
    logic [DATA_W-1:0] periph_wdata;
    logic              hold_req;
    logic              hold_ack;
    logic              bus_idle;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_en;
    logic              mem_we;
    logic              done;

    always #2.5 clk = ~clk;

    dmac_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .periph_req(periph_req), .periph_ack(periph_ack),
        .periph_rdata(periph_rdata), .periph_wdata(periph_wdata),
        .hold_req(hold_req), .hold_ack(hold_ack), .bus_idle(bus_idle),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .done(done)
    );

    // Bench state: memory, processor model, peripheral model, monitors
    logic [7:0]  mem [256];
    logic [7:0]  rx  [16];
    logic [ADDR_W-1:0] alog [16];
    int          ack_delay;
    int          hcnt;
    logic        mon_clr;
    int          ack_n, hold_rises, run_len, max_run, wr_n, viol, src_n;
    logic        hold_q;
    int          checks = 0;
    int          fails  = 0;

    assign mem_rdata    = mem[mem_addr[7:0]];
    assign periph_rdata = 8'hA0 + src_n[7:0];

    // Processor model: grants hold after a programmable delay
    always @(posedge clk) begin
        if (!rst_n || !hold_req) begin
            hold_ack <= 1'b0;
            hcnt     <= 0;
        end else if (hcnt >= ack_delay) begin
            hold_ack <= 1'b1;
        end else begin
            hcnt <= hcnt + 1;
        end
    end

    // Memory, peripheral and bus monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= i[7:0] ^ 8'h5A;
        end else if (mem_en && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (!rst_n || mon_clr) begin
            ack_n <= 0; hold_rises <= 0; run_len <= 0; max_run <= 0;
            wr_n <= 0; viol <= 0; src_n <= 0; hold_q <= 1'b0;
        end else begin
            hold_q <= hold_req;
            if (hold_req && !hold_q) hold_rises <= hold_rises + 1;
            if ((mem_en || periph_ack) && !(hold_req && hold_ack)) viol <= viol + 1;
            if (mem_en && mem_we) wr_n <= wr_n + 1;
            if (periph_ack) begin
                if (ack_n < 16) begin
                    rx[ack_n]   <= periph_wdata;
                    alog[ack_n] <= mem_addr;
                end
                ack_n   <= ack_n + 1;
                src_n   <= src_n + 1;
                run_len <= run_len + 1;
                if (run_len + 1 > max_run) max_run <= run_len + 1;
            end else begin
                run_len <= 0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [CFG_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic wait_done(input int max_cyc);
        int n = 0;
        while (!done && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R8 done reached", done, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!hold_req && !mem_en && !mem_we && !periph_ack && !done,
            "R1 outputs in reset", {hold_req, mem_en, mem_we, periph_ack, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!hold_req && !mem_en && !periph_ack && !done,
            "R1 outputs after reset", {hold_req, mem_en, periph_ack, done}, 0);
    endtask

    task automatic t_zero_count();
        clear_mon();
        periph_req = 1'b1;
        bus_idle   = 1'b1;
        cfg_write(2'd0, 16'h0020);
        cfg_write(2'd1, 16'h0000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'h0004;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(done, "R8 zero count done next cycle", done, 1);
        repeat (6) @(negedge clk);
        chk(hold_rises == 0, "R8 zero count no hold", hold_rises, 0);
        chk(ack_n == 0, "R8 zero count no word", ack_n, 0);
    endtask

    task automatic t_burst_m2p();
        clear_mon();
        periph_req = 1'b0;
        ack_delay  = 3;
        cfg_write(2'd0, 16'h0010);
        cfg_write(2'd1, 16'h0004);
        cfg_write(2'd2, 16'h0004);
        chk(!done, "R8 done cleared on arm", done, 0);
        repeat (8) @(negedge clk);
        chk(hold_rises == 0, "R7 no hold without request", hold_rises, 0);
        cfg_write(2'd0, 16'h0080);
        cfg_write(2'd1, 16'h0002);
        periph_req = 1'b1;
        wait_done(100);
        @(negedge clk);
        chk(ack_n == 4, "R3 one ack per word", ack_n, 4);
        chk(hold_rises == 1, "R4 single hold per burst", hold_rises, 1);
        chk(max_run == 4, "R4 words on consecutive clocks", max_run, 4);
        chk(!hold_req, "R4 hold dropped after block", hold_req, 0);
        chk(wr_n == 0, "R5 no memory write when reading", wr_n, 0);
        chk(viol == 0, "R2 no access without grant", viol, 0);
        for (int k = 0; k < 4; k++) begin
            chk(alog[k] == 16'h0010 + k[15:0], "R3 address order", alog[k], 16'h0010 + k);
            chk(rx[k] == ((8'h10 + k[7:0]) ^ 8'h5A), "R9 R5 data from original range",
                rx[k], (8'h10 + k) ^ 8'h5A);
        end
    endtask

    task automatic t_steal_p2m();
        clear_mon();
        periph_req = 1'b1;
        bus_idle   = 1'b0;
        ack_delay  = 1;
        cfg_write(2'd0, 16'h0040);
        cfg_write(2'd1, 16'h0003);
        cfg_write(2'd2, 16'h0007);
        repeat (10) @(negedge clk);
        chk(hold_rises == 0, "R7 steal waits for idle bus", hold_rises, 0);
        bus_idle = 1'b1;
        wait_done(200);
        @(negedge clk);
        chk(hold_rises == 3, "R6 one grant per word", hold_rises, 3);
        chk(max_run == 1, "R6 single word per grant", max_run, 1);
        chk(ack_n == 3, "R3 steal ack count", ack_n, 3);
        chk(wr_n == 3, "R5 memory writes", wr_n, 3);
        chk(viol == 0, "R2 steal access only with grant", viol, 0);
        for (int k = 0; k < 3; k++)
            chk(mem[8'h40 + k] == 8'hA0 + k[7:0], "R5 peripheral data stored",
                mem[8'h40 + k], 8'hA0 + k);
        chk(mem[8'h43] == (8'h43 ^ 8'h5A), "R3 no write past block",
            mem[8'h43], 8'h43 ^ 8'h5A);
    endtask

    task automatic t_burst_p2m_fast();
        clear_mon();
        periph_req = 1'b1;
        ack_delay  = 0;
        cfg_write(2'd0, 16'h0060);
        cfg_write(2'd1, 16'h0005);
        cfg_write(2'd2, 16'h0006);
        wait_done(100);
        @(negedge clk);
        chk(hold_rises == 1 && max_run == 5, "R4 fast grant burst",
            max_run, 5);
        chk(mem[8'h64] == 8'hA4 && mem[8'h65] == (8'h65 ^ 8'h5A),
            "R3 R5 last word and boundary", mem[8'h64], 8'hA4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        periph_req = 1'b0; bus_idle = 1'b0; ack_delay = 1; mon_clr = 1'b0;
        t_reset();
        t_zero_count();
        t_burst_m2p();
        t_steal_p2m();
        t_burst_p2m_fast();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule